// File: doc/BRIEF.md
# Multi-format 3-wire serial register writer

This block writes one register of an RF transceiver over a 3-wire serial link made of data, clock and a latch enable. A pulse on the start input carries a chip-type code, an address and a value. The block builds a frame whose length, field layout and bit order depend on the chip type. It shifts the frame out one bit at a time. For each bit the data is placed first, then the clock is held high and then low for durations set by parameters in system clock cycles. After the last bit the enable line returns high, which latches the frame in the transceiver.

Chip-type codes that the block does not support are refused. The refusal is a one-cycle error pulse, and no clock edge appears on the link. Busy and done let a controller sequence several writes back to back.

Top module: `rf3w_writer`

## Requirements
- R1: While rst_ni is low and after it is released, sen_o is 1, and sclk_o, sdata_o, busy_o, done_o and err_o are 0.
- R2: A start with chip code 4 to 7 is refused. err_o is 1 for exactly the one cycle after the start edge. busy_o stays 0, sen_o stays 1 and no rising edge appears on sclk_o.
- R3: Chip code 0 sends 16 bits, most significant bit first. The frame is {addr_i[3:0], val_i[11:0]}.
- R4: Chip code 1 sends 32 bits, least significant bit first. The frame is {1'b1, addr_i[6:0], val_i[23:0]}, and bit 31 is the write flag.
- R5: Chip codes 2 and 3 each send 22 bits, most significant bit first. The frame is {addr_i[3:0], val_i[17:0]}.
- R6: Each bit is driven on sdata_o for SETUP_CYC cycles with sclk_o low. Then sclk_o is high for exactly HIGH_CYC cycles, then low for LOW_CYC cycles. sdata_o does not change while sclk_o is high or on the cycle sclk_o rises.
- R7: sen_o goes low in the cycle after an accepted start and stays low through the low phase of the last bit. It returns high together with done_o. sclk_o is never high while sen_o is high.
- R8: busy_o is 1 for exactly len*(SETUP_CYC+HIGH_CYC+LOW_CYC) cycles after an accepted start. done_o is a single-cycle pulse in the first cycle after busy_o falls.
- R9: A start pulse while busy_o is 1 is ignored. The frame in flight is unchanged and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to send a write |
| chip_i | input | 3 | Chip-type code |
| addr_i | input | ADDR_W | Register address |
| val_i | input | VAL_W | Register value |
| sdata_o | output | 1 | Serial data |
| sclk_o | output | 1 | Serial clock |
| sen_o | output | 1 | Latch enable, low while shifting |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse when the frame is latched |
| err_o | output | 1 | One-cycle pulse on a refused chip code |

## Verification
The assertions hold on every cycle for these relations:
- data stays stable while the serial clock is high;
- the clock never pulses outside the enable window;
- the enable rises and busy falls only together with done;
- done and error are single-cycle pulses;
- an error pulse never coincides with activity on the link.

Only the bench scenarios can show the rest: the frame contents and bit order for each chip code, the exact clock-high width, the total frame duration, and that a start pulse arriving mid-frame leaves no trace on the link.

// File: rtl/rf3w_pkg.sv
package rf3w_pkg;
  localparam int FRAME_W = 32;
  localparam int LEN_W   = $clog2(FRAME_W + 1);
  localparam int CHIP_W  = 3;

  localparam int LEN_A  = 16;
  localparam int LEN_B  = 32;
  localparam int LEN_CD = 22;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_HIGH, ST_LOW} st_e;

  typedef struct packed {
    logic             ok;
    logic             lsb_first;
    logic [LEN_W-1:0] len;
  } fmt_t;
endpackage

// File: rtl/rf3w_frame_pack.sv
module rf3w_frame_pack
  import rf3w_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int VAL_W     = 24,
  parameter int A_ADDR_W  = 4,
  parameter int A_VAL_W   = 12,
  parameter int B_ADDR_W  = 7,
  parameter int B_VAL_W   = 24,
  parameter int CD_ADDR_W = 4,
  parameter int CD_VAL_W  = 18
) (
  input  logic [CHIP_W-1:0]  chip_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [VAL_W-1:0]   val_i,
  output fmt_t               fmt_o,
  output logic [FRAME_W-1:0] word_o
);
  function automatic logic [FRAME_W-1:0] pack(input logic [ADDR_W-1:0] a,
                                              input logic [VAL_W-1:0] v,
                                              input int aw, input int vw);
    logic [FRAME_W-1:0] fa, fv;
    fa = FRAME_W'(a) & ((FRAME_W'(1) << aw) - FRAME_W'(1));
    fv = FRAME_W'(v) & ((FRAME_W'(1) << vw) - FRAME_W'(1));
    return fv | (fa << vw);
  endfunction

  logic [FRAME_W-1:0] raw, rev;

  always_comb begin
    fmt_o = '0;
    raw   = '0;
    unique case (chip_i)
      3'd0: begin
        fmt_o = '{ok: 1'b1, lsb_first: 1'b0, len: LEN_W'(LEN_A)};
        raw   = pack(addr_i, val_i, A_ADDR_W, A_VAL_W);
      end
      3'd1: begin
        fmt_o = '{ok: 1'b1, lsb_first: 1'b1, len: LEN_W'(LEN_B)};
        raw   = pack(addr_i, val_i, B_ADDR_W, B_VAL_W) | (FRAME_W'(1) << (LEN_B - 1));
      end
      3'd2, 3'd3: begin
        fmt_o = '{ok: 1'b1, lsb_first: 1'b0, len: LEN_W'(LEN_CD)};
        raw   = pack(addr_i, val_i, CD_ADDR_W, CD_VAL_W);
      end
      default: begin
        fmt_o = '0;
        raw   = '0;
      end
    endcase
  end

  for (genvar i = 0; i < FRAME_W; i++) begin : g_rev
    assign rev[i] = raw[FRAME_W-1-i];
  end

  // first bit to send always lands at the top
  assign word_o = fmt_o.lsb_first ? rev : (raw << (FRAME_W - int'(fmt_o.len)));
endmodule

// File: rtl/rf3w_shreg.sv
module rf3w_shreg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] word_i,
  output logic         bit_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= word_i;
    else if (shift_i) sh_q <= {sh_q[W-2:0], 1'b0};
  end

  assign bit_o = sh_q[W-1];
endmodule

// File: rtl/rf3w_phase_timer.sv
module rf3w_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (load_i)     cnt_q <= val_i;
    else if (cnt_q != 0) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/rf3w_writer.sv
module rf3w_writer
  import rf3w_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int VAL_W     = 24,
  parameter int SETUP_CYC = 2,
  parameter int HIGH_CYC  = 4,
  parameter int LOW_CYC   = 2,
  parameter int A_ADDR_W  = 4,
  parameter int A_VAL_W   = 12,
  parameter int B_ADDR_W  = 7,
  parameter int B_VAL_W   = 24,
  parameter int CD_ADDR_W = 4,
  parameter int CD_VAL_W  = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        chip_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [VAL_W-1:0]  val_i,
  output logic              sdata_o,
  output logic              sclk_o,
  output logic              sen_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int MAX_AB  = (SETUP_CYC > HIGH_CYC) ? SETUP_CYC : HIGH_CYC;
  localparam int MAX_CYC = (MAX_AB > LOW_CYC) ? MAX_AB : LOW_CYC;
  localparam int TMR_W   = $clog2(MAX_CYC + 1);

  st_e                state_q, state_d;
  logic [LEN_W-1:0]   bits_q, bits_d;
  logic               done_q, done_d, err_q, err_d;
  logic               tmr_load, tmr_zero, sh_load, sh_shift, sh_bit;
  logic [TMR_W-1:0]   tmr_val;
  fmt_t               fmt;
  logic [FRAME_W-1:0] word;

  rf3w_frame_pack #(
    .ADDR_W(ADDR_W), .VAL_W(VAL_W),
    .A_ADDR_W(A_ADDR_W), .A_VAL_W(A_VAL_W),
    .B_ADDR_W(B_ADDR_W), .B_VAL_W(B_VAL_W),
    .CD_ADDR_W(CD_ADDR_W), .CD_VAL_W(CD_VAL_W)
  ) u_pack (
    .chip_i(chip_i), .addr_i(addr_i), .val_i(val_i),
    .fmt_o(fmt), .word_o(word)
  );

  rf3w_shreg #(.W(FRAME_W)) u_shreg (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(sh_load), .shift_i(sh_shift),
    .word_i(word), .bit_o(sh_bit)
  );

  rf3w_phase_timer #(.CNT_W(TMR_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .val_i(tmr_val),
    .zero_o(tmr_zero)
  );

  always_comb begin
    state_d  = state_q;
    bits_d   = bits_q;
    done_d   = 1'b0;
    err_d    = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        if (fmt.ok) begin
          state_d  = ST_SETUP;
          sh_load  = 1'b1;
          bits_d   = fmt.len;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(SETUP_CYC - 1);
        end else begin
          err_d = 1'b1;
        end
      end
      ST_SETUP: if (tmr_zero) begin
        state_d  = ST_HIGH;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(HIGH_CYC - 1);
      end
      ST_HIGH: if (tmr_zero) begin
        state_d  = ST_LOW;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(LOW_CYC - 1);
      end
      ST_LOW: if (tmr_zero) begin
        if (bits_q == LEN_W'(1)) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d  = ST_SETUP;
          sh_shift = 1'b1;
          bits_d   = bits_q - LEN_W'(1);
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(SETUP_CYC - 1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bits_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bits_q  <= bits_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign sen_o   = (state_q == ST_IDLE);
  assign sclk_o  = (state_q == ST_HIGH);
  assign sdata_o = busy_o & sh_bit;
  assign done_o  = done_q;
  assign err_o   = err_q;
endmodule

// File: rtl/rf3w_writer_chk.sv
module rf3w_writer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sdata_o,
  input logic sclk_o,
  input logic sen_o,
  input logic busy_o,
  input logic done_o,
  input logic err_o
);
  a_r6_data_stable_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

  a_r7_clk_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !sen_o);

  a_r7_sen_rise_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sen_o) |-> done_o);

  a_r8_busy_fall_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r2_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (sen_o && !busy_o && !sclk_o));

  a_r2_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
endmodule

bind rf3w_writer rf3w_writer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sdata_o(sdata_o), .sclk_o(sclk_o),
  .sen_o(sen_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/rf3w_writer_bench.sv
module rf3w_writer_bench;
  localparam int CLK_P = 10;
  localparam int S_C = 2, H_C = 4, L_C = 2;
  localparam int PER = S_C + H_C + L_C;

  typedef struct packed {
    logic [2:0]  chip;
    logic [7:0]  addr;
    logic [23:0] val;
    logic [31:0] exp;
    logic [5:0]  len;
    logic        lsb;
  } vec_t;

  // R3: 16'h5456/16'hFFFF, R4: flag+addr7+val24, R5: addr4+val18
  localparam vec_t VECS [6] = '{
    '{3'd0, 8'hA5, 24'h123456, 32'h0000_5456, 6'd16, 1'b0},
    '{3'd1, 8'h81, 24'hABCDEF, 32'h81AB_CDEF, 6'd32, 1'b1},
    '{3'd2, 8'h3C, 24'hFFFFFF, 32'h0033_FFFF, 6'd22, 1'b0},
    '{3'd3, 8'h07, 24'h000001, 32'h001C_0001, 6'd22, 1'b0},
    '{3'd1, 8'h00, 24'h000000, 32'h8000_0000, 6'd32, 1'b1},
    '{3'd0, 8'hFF, 24'hFFFFFF, 32'h0000_FFFF, 6'd16, 1'b0}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [2:0] chip_i = '0;
  logic [7:0] addr_i = '0;
  logic [23:0] val_i = '0;
  logic sdata_o, sclk_o, sen_o, busy_o, done_o, err_o;

  int n_chk = 0, n_err = 0;

  rf3w_writer #(.SETUP_CYC(S_C), .HIGH_CYC(H_C), .LOW_CYC(L_C)) u_rf3w_writer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .chip_i(chip_i),
    .addr_i(addr_i), .val_i(val_i), .sdata_o(sdata_o), .sclk_o(sclk_o),
    .sen_o(sen_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  // link monitor, sampled away from the active edge
  logic [31:0] rx_msb = '0, rx_lsb = '0;
  int edges = 0, busy_cyc = 0, sen_low = 0, hi_bad = 0, dchg = 0, hi_run = 0;
  int dones = 0, errs = 0;
  logic sclk_p = 1'b0, sdata_p = 1'b0;

  always @(negedge clk_i) begin
    if (sclk_o && !sclk_p) begin
      edges++;
      rx_msb = {rx_msb[30:0], sdata_o};
      rx_lsb = {sdata_o, rx_lsb[31:1]};
      if (sdata_o != sdata_p) dchg++;
    end
    if (sclk_o && sclk_p && sdata_o != sdata_p) dchg++;
    if (sclk_o) hi_run++;
    else if (sclk_p) begin
      if (hi_run != H_C) hi_bad++;
      hi_run = 0;
    end
    if (busy_o) busy_cyc++;
    if (!sen_o) sen_low++;
    if (done_o) dones++;
    if (err_o) errs++;
    sclk_p  = sclk_o;
    sdata_p = sdata_o;
  end

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [2:0] c, input logic [7:0] a, input logic [23:0] v);
    @(posedge clk_i); #1;
    chip_i = c; addr_i = a; val_i = v; start_i = 1'b1;
    @(posedge clk_i); #1;
    start_i = 1'b0;
  endtask

  task automatic wait_done(output logic seen);
    seen = 1'b0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk_i); #1;
      if (done_o) begin seen = 1'b1; break; end
    end
  endtask

  task automatic run_frame(input vec_t v, input string tag);
    int e0, b0, d0, hb0, dc0, s0;
    logic seen;
    logic [31:0] got, msk;
    e0 = edges; b0 = busy_cyc; d0 = dones; hb0 = hi_bad; dc0 = dchg; s0 = sen_low;
    pulse(v.chip, v.addr, v.val);
    wait_done(seen);
    msk = (v.len == 6'd32) ? 32'hFFFF_FFFF : ((32'h1 << v.len) - 32'h1);
    got = v.lsb ? rx_lsb : (rx_msb & msk);
    chk(seen, {tag, " done seen"}, seen, 1);
    chk(got == v.exp, {tag, " frame"}, got, v.exp);
    chk(edges - e0 == int'(v.len), {tag, " R6 edge count"}, edges - e0, v.len);
    chk(hi_bad == hb0 && dchg == dc0, "R6 clk high width / data hold", hi_bad - hb0, 0);
    chk(busy_cyc - b0 == int'(v.len) * PER, "R8 busy length", busy_cyc - b0, int'(v.len) * PER);
    chk(sen_low - s0 == int'(v.len) * PER, "R7 enable low window", sen_low - s0, int'(v.len) * PER);
    chk(sen_o && !busy_o, "R7 enable high at done", sen_o, 1);
    @(negedge clk_i); #1;
    chk(!done_o && dones - d0 == 1, "R8 done single pulse", dones - d0, 1);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int e0, b0, s0;
    logic seen;
    vec_t v;
    // R1 reset
    repeat (3) @(negedge clk_i);
    chk(sen_o && !sclk_o && !sdata_o && !busy_o && !done_o && !err_o, "R1 in reset",
        {sen_o, sclk_o, sdata_o, busy_o, done_o, err_o}, 6'b100000);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(sen_o && !sclk_o && !busy_o && !done_o && !err_o, "R1 after release",
        {sen_o, sclk_o, busy_o, done_o, err_o}, 5'b10000);

    foreach (VECS[i]) begin
      v = VECS[i];
      run_frame(v, v.chip == 3'd0 ? "R3" : v.chip == 3'd1 ? "R4" : "R5");
    end

    // R2 refused codes
    for (int c = 4; c < 8; c++) begin
      e0 = edges; b0 = busy_cyc; s0 = sen_low;
      pulse(3'(c), 8'h11, 24'h222222);
      @(negedge clk_i); #1;
      chk(err_o, "R2 err pulse", err_o, 1);
      @(negedge clk_i); #1;
      chk(!err_o, "R2 err single cycle", err_o, 0);
      repeat (20) @(negedge clk_i);
      chk(edges == e0 && busy_cyc == b0 && sen_low == s0, "R2 link quiet",
          edges - e0 + busy_cyc - b0 + sen_low - s0, 0);
    end

    // R9 start during a frame is ignored
    e0 = edges; b0 = busy_cyc;
    pulse(3'd0, 8'hA5, 24'h123456);
    repeat (40) @(negedge clk_i);
    pulse(3'd1, 8'h7F, 24'h00FF00);
    wait_done(seen);
    chk(seen && (rx_msb & 32'hFFFF) == 32'h5456, "R9 frame unchanged", rx_msb & 32'hFFFF, 32'h5456);
    chk(edges - e0 == 16, "R9 edge count", edges - e0, 16);
    e0 = edges; b0 = busy_cyc;
    repeat (300) @(negedge clk_i);
    chk(edges == e0 && busy_cyc == b0, "R9 no second frame", edges - e0, 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule